// File: doc/BRIEF.md
# Block-Sparsity Fetch Skipper

This block sits beside a weight-fetch controller and walks a layer one block at a time, where a block is eight consecutive input channels of a single output channel. A coarse sparsity mask arrives as a stream carrying one bit per block, in the same order the weights are fetched: output channel outer, block inner. A set bit means the block holds useful weights. The block then issues one burst request for the weight line and one for the matching activation line. A clear bit means the block was pruned. Both requests are dropped, and no address needs adjusting, because every block fills exactly one 64-bit line of eight 8-bit values.

For every block that carries work, the block pulses a clock-gate enable for the MAC stage of that output channel. A pruned block leaves that stage gated for the round. Pruning must be balanced: every output channel zeroes the same number of blocks, a multiple of four, and the expected count is given at layer start. The block counts zero bits per output channel and raises a sticky error when a channel breaks that rule. Counters of issued and skipped blocks let a test confirm that every block was accounted for.

Request channels use a valid/ready handshake. While a block's requests wait to be accepted, the mask stream is stalled, so mask bits never drift out of step with blocks.

Top module: `blkmask_fetch_skip`

## Requirements
- R1: After reset, mask_ready, wt_req_valid, act_req_valid, every mac_gate_en bit, busy, layer_done and prune_err are 0, and issued_cnt and skipped_cnt are 0.
- R2: A mask bit of 1 accepted for output channel o and block b (blocks per channel = input channels / 8) produces exactly one weight request and one activation request. The weight address is WT_BASE + (o*blocks_per_channel + b)*8 and the activation address is ACT_BASE + b*8. Requests come out in mask order.
- R3: A mask bit of 0 produces no request for its block. A later kept block still uses its own line address, so the weight address simply advances by one line per block whether or not blocks in between were skipped.
- R4: While a weight or activation request is valid and not yet accepted, that request keeps its valid and address unchanged, and mask_ready is 0.
- R5: One cycle after a kept block's requests have all been accepted, mac_gate_en has only bit o set (o being that block's output channel) for one cycle. A skipped block sets no bit. At most one bit is ever set.
- R6: issued_cnt counts kept blocks and skipped_cnt counts pruned blocks of the current layer. Both clear when a layer starts, and when layer_done pulses their sum equals output channels times blocks per channel.
- R7: prune_err is set at the end of any output channel whose zero-bit count differs from exp_zero_cnt (sampled at start) or is not a multiple of 4. It stays set until the next accepted start.
- R8: start is accepted only while busy is 0. busy goes high the cycle after an accepted start and falls in the same cycle that the one-cycle layer_done pulse appears, after the last block. A start while busy has no effect on counters, expected count or addresses.
- R9: A layer with every bit 0 issues no request and no gate pulse. A layer with every bit 1 issues a request pair for every block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a layer (ignored while busy) |
| exp_zero_cnt | input | 5 | Expected pruned blocks per output channel, sampled at start |
| mask_valid | input | 1 | Mask bit available |
| mask_bit | input | 1 | 1 = block has work, 0 = block pruned |
| mask_ready | output | 1 | Block accepts a mask bit this cycle |
| wt_req_valid | output | 1 | Weight burst request valid |
| wt_req_addr | output | 32 | Weight burst byte address |
| wt_req_ready | input | 1 | Memory accepts weight request |
| act_req_valid | output | 1 | Activation burst request valid |
| act_req_addr | output | 32 | Activation burst byte address |
| act_req_ready | input | 1 | Memory accepts activation request |
| mac_gate_en | output | 16 | Per output channel MAC clock-gate enable, one round pulse |
| busy | output | 1 | Layer in progress |
| layer_done | output | 1 | One-cycle pulse after the last block |
| prune_err | output | 1 | Sticky unbalanced-pruning flag |
| issued_cnt | output | 9 | Kept blocks this layer |
| skipped_cnt | output | 9 | Pruned blocks this layer |

## Verification
The bench goes after blocks skipped between kept ones. A design that realigned or compacted addresses would issue the wrong line there. It also targets memory back-pressure on one channel but not the other, where a design that advanced the mask early or let a held address change would skew every later block. A channel whose zero count matches the expected value but is not a multiple of four must still flag an error, as must a single extra zero in one channel. Fully pruned and fully kept layers catch gate pulses on skipped blocks or missing request pairs. A start pulse in the middle of a layer catches a design that restarts, because its counters would no longer add up to the block total.

// File: rtl/bmfs_pkg.sv
package bmfs_pkg;
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_MASK  = 2'd1,
      WK_ISSUE = 2'd2
   } walk_state_e;

   localparam int CH_WT  = 0;
   localparam int CH_ACT = 1;
   localparam int CH_N   = 2;
endpackage

// File: rtl/bmfs_walker.sv
module bmfs_walker
   import bmfs_pkg::*;
#(
   parameter int OC_N = 16,
   parameter int BPO  = 16,
   parameter int OCW  = 4,
   parameter int BW   = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_acc,
   input  logic           mask_valid,
   input  logic           mask_bit,
   output logic           mask_ready,
   input  logic           slots_clear,
   input  logic           slots_pend,
   output logic           load_req,
   output logic [OCW-1:0] oc_idx,
   output logic [BW-1:0]  blk_idx,
   output logic           retire,
   output logic           retire_keep,
   output logic           last_blk,
   output logic           busy,
   output logic           layer_done
);
   walk_state_e state;
   logic        accept;
   logic        last_oc;

   assign mask_ready  = (state == WK_MASK);
   assign accept      = mask_ready && mask_valid;
   assign load_req    = accept && mask_bit;
   assign retire_keep = (state == WK_ISSUE);
   assign retire      = (accept && !mask_bit) || (retire_keep && slots_clear);
   assign last_blk    = (blk_idx == BW'(BPO - 1));
   assign last_oc     = (oc_idx == OCW'(OC_N - 1));
   assign busy        = (state != WK_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= WK_IDLE;
         oc_idx     <= '0;
         blk_idx    <= '0;
         layer_done <= 1'b0;
      end else begin
         layer_done <= 1'b0;
         case (state)
            WK_IDLE: begin
               if (start_acc) begin
                  state   <= WK_MASK;
                  oc_idx  <= '0;
                  blk_idx <= '0;
               end
            end
            WK_MASK: begin
               if (load_req) state <= WK_ISSUE;
            end
            default: ;
         endcase
         if (retire) begin
            if (last_blk && last_oc) begin
               state      <= WK_IDLE;
               layer_done <= 1'b1;
            end else begin
               state <= WK_MASK;
               if (last_blk) begin
                  blk_idx <= '0;
                  oc_idx  <= oc_idx + 1'b1;
               end else begin
                  blk_idx <= blk_idx + 1'b1;
               end
            end
         end
      end
   end

   // R4: mask stream is held while any request of the block is pending
   a_r4_mask_stall: assert property (@(posedge clk) disable iff (!rst_n)
      slots_pend |-> !mask_ready);

   // R8: the done pulse only follows a block retirement
   a_r8_done_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
      layer_done |-> !busy && $past(retire));
endmodule

// File: rtl/bmfs_req_slot.sv
module bmfs_req_slot #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   output logic          req_valid,
   output logic [AW-1:0] req_addr,
   input  logic          req_ready,
   output logic          clear_next
);
   assign clear_next = !req_valid || req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_addr  <= '0;
      end else if (load) begin
         req_valid <= 1'b1;
         req_addr  <= load_addr;
      end else if (req_valid && req_ready) begin
         req_valid <= 1'b0;
      end
   end

   // R4: a stalled request keeps valid and address
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr));

   // R4: a new block never overwrites a request still waiting
   a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !req_valid);
endmodule

// File: rtl/bmfs_prune_chk.sv
module bmfs_prune_chk #(
   parameter int BPO   = 16,
   parameter int TOTAL = 256,
   parameter int STEP  = 4,
   parameter int ZCW   = 5,
   parameter int CNTW  = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_acc,
   input  logic [ZCW-1:0]  exp_in,
   input  logic            retire,
   input  logic            keep,
   input  logic            last_blk,
   output logic            prune_err,
   output logic [CNTW-1:0] issued_cnt,
   output logic [CNTW-1:0] skipped_cnt
);
   logic [ZCW-1:0] exp_q;
   logic [ZCW-1:0] zc;
   logic [ZCW-1:0] zc_final;
   logic           step_ok;
   logic           oc_bad;

   assign zc_final = zc + ZCW'(!keep);

   if (STEP <= 1) begin : g_step_any
      assign step_ok = 1'b1;
   end else if ((STEP & (STEP - 1)) == 0) begin : g_step_pow2
      localparam int SLW = $clog2(STEP);
      assign step_ok = (zc_final[SLW-1:0] == '0);
   end else begin : g_step_gen
      assign step_ok = ((32'(zc_final) % STEP) == 0);
   end

   assign oc_bad = (zc_final != exp_q) || !step_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q       <= '0;
         zc          <= '0;
         prune_err   <= 1'b0;
         issued_cnt  <= '0;
         skipped_cnt <= '0;
      end else if (start_acc) begin
         exp_q       <= exp_in;
         zc          <= '0;
         prune_err   <= 1'b0;
         issued_cnt  <= '0;
         skipped_cnt <= '0;
      end else if (retire) begin
         if (keep) issued_cnt  <= issued_cnt + 1'b1;
         else      skipped_cnt <= skipped_cnt + 1'b1;
         if (last_blk) begin
            zc <= '0;
            if (oc_bad) prune_err <= 1'b1;
         end else begin
            zc <= zc_final;
         end
      end
   end

   // R6: block accounting never exceeds the layer size
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, issued_cnt} + {1'b0, skipped_cnt}) <= (CNTW + 1)'(TOTAL));

   // R7: the error flag is sticky within a layer
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      prune_err && !start_acc |=> prune_err);

   // R7: the per-channel zero count stays within the channel
   a_r7_zc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      zc < ZCW'(BPO));
endmodule

// File: rtl/bmfs_gate_drv.sv
module bmfs_gate_drv #(
   parameter int OC_N = 16,
   parameter int OCW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            retire,
   input  logic            keep,
   input  logic [OCW-1:0]  oc_idx,
   output logic [OC_N-1:0] mac_gate_en
);
   for (genvar g = 0; g < OC_N; g++) begin : g_gate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mac_gate_en[g] <= 1'b0;
         else        mac_gate_en[g] <= retire && keep && (oc_idx == OCW'(g));
      end
   end

   // R5: at most one MAC stage is enabled per round
   a_r5_gate_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mac_gate_en));

   // R5: a gate pulse lasts a single round
   a_r5_gate_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      |mac_gate_en |=> (mac_gate_en & $past(mac_gate_en)) == '0);
endmodule

// File: rtl/blkmask_fetch_skip.sv
module blkmask_fetch_skip
   import bmfs_pkg::*;
#(
   parameter int            IC_N     = 128,
   parameter int            OC_N     = 16,
   parameter int            BLK_CH   = 8,
   parameter int            ELEM_W   = 8,
   parameter int            LINE_W   = 64,
   parameter int            STEP     = 4,
   parameter int            AW       = 32,
   parameter logic [AW-1:0] WT_BASE  = 32'h0001_0000,
   parameter logic [AW-1:0] ACT_BASE = 32'h0008_0000,
   localparam int           BPO      = IC_N / BLK_CH,
   localparam int           TOTAL    = OC_N * BPO,
   localparam int           ZCW      = $clog2(BPO + 1),
   localparam int           CNTW     = $clog2(TOTAL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [ZCW-1:0]  exp_zero_cnt,
   input  logic            mask_valid,
   input  logic            mask_bit,
   output logic            mask_ready,
   output logic            wt_req_valid,
   output logic [AW-1:0]   wt_req_addr,
   input  logic            wt_req_ready,
   output logic            act_req_valid,
   output logic [AW-1:0]   act_req_addr,
   input  logic            act_req_ready,
   output logic [OC_N-1:0] mac_gate_en,
   output logic            busy,
   output logic            layer_done,
   output logic            prune_err,
   output logic [CNTW-1:0] issued_cnt,
   output logic [CNTW-1:0] skipped_cnt
);
   localparam int LINE_BYTES = LINE_W / 8;
   localparam int LSH        = $clog2(LINE_BYTES);
   localparam int OCW        = (OC_N > 1) ? $clog2(OC_N) : 1;
   localparam int BW         = (BPO > 1) ? $clog2(BPO) : 1;

   if (IC_N % BLK_CH != 0) begin : g_bad_ic
      $error("IC_N must be a whole number of blocks");
   end
   if (BLK_CH * ELEM_W != LINE_W) begin : g_bad_line
      $error("a block must fill exactly one memory line");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_lb
      $error("line size must be a power of two bytes");
   end
   if (STEP < 1) begin : g_bad_step
      $error("STEP must be at least 1");
   end

   logic            start_acc;
   logic            load_req;
   logic [OCW-1:0]  oc_idx;
   logic [BW-1:0]   blk_idx;
   logic            retire;
   logic            retire_keep;
   logic            last_blk;
   logic            slots_clear;
   logic            slots_pend;
   logic [AW-1:0]   slot_ld_addr [CH_N];
   logic [AW-1:0]   slot_addr    [CH_N];
   logic [CH_N-1:0] slot_valid;
   logic [CH_N-1:0] slot_ready;
   logic [CH_N-1:0] slot_clr;

   assign start_acc = start && !busy;

   assign slot_ld_addr[CH_WT]  = WT_BASE +
      ((AW'(oc_idx) * AW'(BPO) + AW'(blk_idx)) << LSH);
   assign slot_ld_addr[CH_ACT] = ACT_BASE + (AW'(blk_idx) << LSH);

   assign slot_ready[CH_WT]  = wt_req_ready;
   assign slot_ready[CH_ACT] = act_req_ready;
   assign slots_clear        = &slot_clr;
   assign slots_pend         = |slot_valid;

   bmfs_walker #(
      .OC_N(OC_N), .BPO(BPO), .OCW(OCW), .BW(BW)
   ) u_walker (
      .clk(clk), .rst_n(rst_n), .start_acc(start_acc),
      .mask_valid(mask_valid), .mask_bit(mask_bit), .mask_ready(mask_ready),
      .slots_clear(slots_clear), .slots_pend(slots_pend),
      .load_req(load_req), .oc_idx(oc_idx), .blk_idx(blk_idx),
      .retire(retire), .retire_keep(retire_keep), .last_blk(last_blk),
      .busy(busy), .layer_done(layer_done)
   );

   for (genvar g = 0; g < CH_N; g++) begin : g_slot
      bmfs_req_slot #(.AW(AW)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .load(load_req), .load_addr(slot_ld_addr[g]),
         .req_valid(slot_valid[g]), .req_addr(slot_addr[g]),
         .req_ready(slot_ready[g]), .clear_next(slot_clr[g])
      );
   end

   assign wt_req_valid  = slot_valid[CH_WT];
   assign wt_req_addr   = slot_addr[CH_WT];
   assign act_req_valid = slot_valid[CH_ACT];
   assign act_req_addr  = slot_addr[CH_ACT];

   bmfs_prune_chk #(
      .BPO(BPO), .TOTAL(TOTAL), .STEP(STEP), .ZCW(ZCW), .CNTW(CNTW)
   ) u_chk (
      .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .exp_in(exp_zero_cnt),
      .retire(retire), .keep(retire_keep), .last_blk(last_blk),
      .prune_err(prune_err), .issued_cnt(issued_cnt), .skipped_cnt(skipped_cnt)
   );

   bmfs_gate_drv #(.OC_N(OC_N), .OCW(OCW)) u_gate (
      .clk(clk), .rst_n(rst_n), .retire(retire), .keep(retire_keep),
      .oc_idx(oc_idx), .mac_gate_en(mac_gate_en)
   );

   // R3: a pruned block raises no request in the following cycle
   a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid && mask_ready && !mask_bit |=> !wt_req_valid && !act_req_valid);

   // R5: a gate pulse follows an accepted request handshake
   a_r5_gate_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      |mac_gate_en |-> $past((wt_req_valid && wt_req_ready) ||
                             (act_req_valid && act_req_ready)));

   // R6: every block of the layer is accounted for at completion
   a_r6_sum_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      layer_done |-> ({1'b0, issued_cnt} + {1'b0, skipped_cnt}) == (CNTW + 1)'(TOTAL));
endmodule

// File: tb/blkmask_fetch_skip_bench.sv
module blkmask_fetch_skip_bench;
   localparam int OC_N  = 16;
   localparam int BPO   = 16;
   localparam int TOTAL = OC_N * BPO;
   localparam logic [31:0] WT_BASE  = 32'h0001_0000;
   localparam logic [31:0] ACT_BASE = 32'h0008_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  exp_zero_cnt = '0;
   logic        mask_valid = 1'b0;
   logic        mask_bit = 1'b0;
   logic        mask_ready;
   logic        wt_req_valid, act_req_valid;
   logic [31:0] wt_req_addr, act_req_addr;
   logic        wt_req_ready = 1'b0, act_req_ready = 1'b0;
   logic [15:0] mac_gate_en;
   logic        busy, layer_done, prune_err;
   logic [8:0]  issued_cnt, skipped_cnt;

   always #2 clk = ~clk;

   blkmask_fetch_skip u_blkmask_fetch_skip (
      .clk(clk), .rst_n(rst_n), .start(start), .exp_zero_cnt(exp_zero_cnt),
      .mask_valid(mask_valid), .mask_bit(mask_bit), .mask_ready(mask_ready),
      .wt_req_valid(wt_req_valid), .wt_req_addr(wt_req_addr), .wt_req_ready(wt_req_ready),
      .act_req_valid(act_req_valid), .act_req_addr(act_req_addr), .act_req_ready(act_req_ready),
      .mac_gate_en(mac_gate_en), .busy(busy), .layer_done(layer_done),
      .prune_err(prune_err), .issued_cnt(issued_cnt), .skipped_cnt(skipped_cnt)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit reported = 1'b0;
   bit ready_rand = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   logic [31:0] exp_wt_q[$];
   logic [31:0] exp_act_q[$];
   int          exp_gate_q[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      end
   endtask

   // monitor: drives readies and checks results at the falling edge
   logic        pv_wt = 1'b0, pr_wt = 1'b0, pv_act = 1'b0, pr_act = 1'b0;
   logic [31:0] pa_wt = '0, pa_act = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pv_wt && !pr_wt)
            chk(wt_req_valid && wt_req_addr == pa_wt, "R4 weight hold", 64'(wt_req_addr), 64'(pa_wt));
         if (pv_act && !pr_act)
            chk(act_req_valid && act_req_addr == pa_act, "R4 activation hold", 64'(act_req_addr), 64'(pa_act));
         if (wt_req_valid || act_req_valid)
            chk(!mask_ready, "R4 mask stalled", 64'(mask_ready), 64'd0);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         wt_req_ready  = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
         act_req_ready = ready_rand ? (lfsr[5] & lfsr[9]) : 1'b1;
         if (wt_req_valid && wt_req_ready) begin
            if (exp_wt_q.size() == 0) chk(1'b0, "R2 R3 unexpected weight request", 64'(wt_req_addr), 64'd0);
            else begin
               logic [31:0] e;
               e = exp_wt_q.pop_front();
               chk(wt_req_addr == e, "R2 R3 weight address", 64'(wt_req_addr), 64'(e));
            end
         end
         if (act_req_valid && act_req_ready) begin
            if (exp_act_q.size() == 0) chk(1'b0, "R2 unexpected activation request", 64'(act_req_addr), 64'd0);
            else begin
               logic [31:0] e;
               e = exp_act_q.pop_front();
               chk(act_req_addr == e, "R2 activation address", 64'(act_req_addr), 64'(e));
            end
         end
         if (mac_gate_en != '0) begin
            chk($onehot(mac_gate_en), "R5 single gate", 64'(mac_gate_en), 64'd1);
            if (exp_gate_q.size() == 0) chk(1'b0, "R5 unexpected gate pulse", 64'(mac_gate_en), 64'd0);
            else begin
               int o;
               o = exp_gate_q.pop_front();
               chk(mac_gate_en == (16'd1 << o), "R5 gate channel", 64'(mac_gate_en), 64'(16'd1 << o));
            end
         end
         pv_wt = wt_req_valid;  pr_wt = wt_req_ready;  pa_wt = wt_req_addr;
         pv_act = act_req_valid; pr_act = act_req_ready; pa_act = act_req_addr;
      end
   end

   function automatic bit keep_bit(input int mode, input int oc, input int b);
      case (mode)
         0: return ((b + oc) % 4) != 0;
         1: return 1'b1;
         2: return 1'b0;
         3: return !(((b + oc) % 4) == 0 || (oc == 5 && b == 2));
         4: return !(b == (oc % 16) || b == ((oc + 7) % 16));
         default: return ((b * 5 + oc) % 2) != 0;
      endcase
   endfunction

   task automatic send_bit(input bit bv, input bit gap);
      if (gap) begin
         mask_valid = 1'b0;
         @(negedge clk);
      end
      mask_valid = 1'b1;
      mask_bit   = bv;
      while (!mask_ready) @(negedge clk);
      @(negedge clk);
      mask_valid = 1'b0;
   endtask

   task automatic run_layer(input int mode, input int expz, input bit rnd,
                            input bit gaps, input bit mid_start, input string name);
      bit exp_err = 1'b0;
      int kept = 0;
      ready_rand = rnd;
      exp_zero_cnt = 5'(expz);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, {"R8 busy after start ", name}, 64'(busy), 64'd1);
      chk(issued_cnt == 0 && skipped_cnt == 0, {"R6 counters cleared ", name},
          64'(issued_cnt + skipped_cnt), 64'd0);
      for (int oc = 0; oc < OC_N; oc++) begin
         int zc = 0;
         for (int b = 0; b < BPO; b++) begin
            bit kb;
            kb = keep_bit(mode, oc, b);
            if (mid_start && oc == 8 && b == 0) begin
               start = 1'b1;
               exp_zero_cnt = 5'd9;
               @(negedge clk);
               start = 1'b0;
               exp_zero_cnt = 5'(expz);
            end
            if (kb) begin
               exp_wt_q.push_back(WT_BASE + 32'((oc * BPO + b) * 8));
               exp_act_q.push_back(ACT_BASE + 32'(b * 8));
               exp_gate_q.push_back(oc);
               kept++;
            end else begin
               zc++;
            end
            send_bit(kb, gaps && ((oc + b) % 5 == 0));
         end
         if (zc != expz || (zc % 4) != 0) exp_err = 1'b1;
      end
      begin
         int guard = 0;
         while (!layer_done && guard < 1000) begin
            @(negedge clk);
            guard++;
         end
         chk(layer_done == 1'b1, {"R8 layer_done ", name}, 64'(layer_done), 64'd1);
      end
      chk(busy == 1'b0, {"R8 idle at done ", name}, 64'(busy), 64'd0);
      chk(issued_cnt == 9'(kept), {"R6 issued ", name}, 64'(issued_cnt), 64'(kept));
      chk(skipped_cnt == 9'(TOTAL - kept), {"R6 skipped ", name}, 64'(skipped_cnt), 64'(TOTAL - kept));
      chk(prune_err == exp_err, {"R7 prune_err ", name}, 64'(prune_err), 64'(exp_err));
      @(negedge clk);
      chk(layer_done == 1'b0, {"R8 done is a pulse ", name}, 64'(layer_done), 64'd0);
      chk(exp_wt_q.size() == 0 && exp_act_q.size() == 0, {"R2 R9 all requests seen ", name},
          64'(exp_wt_q.size() + exp_act_q.size()), 64'd0);
      chk(exp_gate_q.size() == 0, {"R5 R9 all gates seen ", name}, 64'(exp_gate_q.size()), 64'd0);
      chk(prune_err == exp_err, {"R7 prune_err held ", name}, 64'(prune_err), 64'(exp_err));
      exp_wt_q.delete();
      exp_act_q.delete();
      exp_gate_q.delete();
   endtask

   initial begin
      #(4 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(mask_ready == 0 && wt_req_valid == 0 && act_req_valid == 0, "R1 reset requests",
          64'({mask_ready, wt_req_valid, act_req_valid}), 64'd0);
      chk(mac_gate_en == 0 && busy == 0 && layer_done == 0 && prune_err == 0, "R1 reset flags",
          64'({mac_gate_en, busy, layer_done, prune_err}), 64'd0);
      chk(issued_cnt == 0 && skipped_cnt == 0, "R1 reset counters",
          64'({issued_cnt, skipped_cnt}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mask_ready == 1'b0 && busy == 1'b0, "R1 idle without start",
          64'({mask_ready, busy}), 64'd0);
      run_layer(0, 4, 1'b0, 1'b0, 1'b0, "quarter pruning");
      run_layer(1, 0, 1'b1, 1'b0, 1'b0, "all kept R9");
      run_layer(2, 16, 1'b0, 1'b1, 1'b0, "all pruned R9");
      run_layer(3, 4, 1'b1, 1'b0, 1'b0, "extra zero R7");
      run_layer(4, 2, 1'b0, 1'b0, 1'b0, "count not multiple of four R7");
      run_layer(5, 8, 1'b1, 1'b1, 1'b1, "start while busy R8");
      run_layer(0, 4, 1'b1, 1'b1, 1'b0, "error cleared by start R7");
      report();
      $finish;
   end
endmodule